// File: doc/BRIEF.md
# Per-Core Interval Tick Timer

This block is a local event timer meant for one processor core. It chains two down-counting stages: a prescaler that divides the input clock by a programmable amount to make ticks, and an interrupt counter that counts those ticks. When the interrupt counter runs out, the block sets a sticky expiry flag. The flag reaches the interrupt line when the enable bit allows it. In interval mode both stages reload themselves and events keep coming at a fixed period. Without interval mode the timer fires once and then holds.

Software programs the block through a small word-wide register port. The port carries an 8-bit local offset, so one copy fits in each 0x100-byte window of a larger timer map. The interrupt count register has a separate update bit, so the active count changes only when software asks for it. Counting also needs two start bits, one for the prescaler and one for the interrupt counter, and both must be set.

Top module: `local_tick_timer`

## Requirements
- R1: After reset every register reads 0 and `irq_o` is low.
- R2: With prescaler buffer T, the prescaler produces one tick every T+1 clocks. With active interrupt count N, the first expiry is flagged exactly N*(T+1) clock edges after the edge that accepted the start write.
- R3: Reads are combinational from `addr_i` at these offsets: 0x00 prescaler buffer, 0x08 interrupt count buffer, 0x20 control bits [2:0], 0x30 status bit 0, 0x34 enable bit 0. Any other offset reads 0.
- R4: Writing 0x08 with bit 31 set loads bits [30:0] as the active interrupt count, which is used at the next start or reload. With bit 31 clear the active count stays unchanged. Offset 0x08 always reads back the last written value with bit 31 forced to 0.
- R5: Control bit 0 enables the prescaler and bit 1 enables interrupt counting. Both counters advance only while both bits are 1. Clearing either bit freezes both counters. A write that sets both bits when they were not both set reloads both stages from their buffers.
- R6: With control bit 2 set (interval mode), expiries recur every N*(T+1) clocks for as long as both start bits stay set.
- R7: With control bit 2 clear, the timer flags exactly one expiry after a start and then holds its interrupt counter at zero.
- R8: Status bit 0 is sticky. Writing 1 to bit 0 of 0x30 clears it and writing 0 has no effect. An expiry in the same cycle as the clear leaves the flag set.
- R9: `irq_o` is high exactly when status bit 0 and enable bit 0 are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Timer and register clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | Write qualifier for `req_i` |
| addr_i | input | 8 | Local byte offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i` |
| irq_o | output | 1 | Interrupt, status gated by enable |

## Verification
The assertions assume that every active interrupt count lies between 0xF and 0x7FFFFFFF. Counts of 0 and 1 both collapse to an expiry on every tick. The assertions also assume that software never asserts a write strobe with an unknown offset. The stimulus uses only counts from 15 upwards. It sweeps the prescaler value from 0 to 3 and keeps both buffers stable while a period is being measured. Every register write is a single-cycle strobe driven on the falling edge, so each start edge lines up with a known cycle count.

// File: rtl/lt_pkg.sv
`timescale 1ns/1ps
package lt_pkg;
  localparam int unsigned ADDR_W = 8;
  localparam int unsigned DATA_W = 32;

  localparam logic [ADDR_W-1:0] OFF_TICK = 8'h00;
  localparam logic [ADDR_W-1:0] OFF_ICNT = 8'h08;
  localparam logic [ADDR_W-1:0] OFF_CTL  = 8'h20;
  localparam logic [ADDR_W-1:0] OFF_STAT = 8'h30;
  localparam logic [ADDR_W-1:0] OFF_EN   = 8'h34;

  localparam int unsigned UPD_BIT = 31;

  // field order matches control bit positions [2:0]
  typedef struct packed {
    logic interval;
    logic int_run;
    logic tick_run;
  } ctl_t;
endpackage

// File: rtl/lt_prescaler.sv
`timescale 1ns/1ps
module lt_prescaler #(
  parameter int unsigned TICK_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              load_i,
  input  logic [TICK_W-1:0] reload_i,
  output logic              tick_o
);
  logic [TICK_W-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (load_i)   cnt_q <= reload_i;
    else if (tick_o)   cnt_q <= reload_i;
    else if (run_i)    cnt_q <= cnt_q - 1'b1;
  end

  assert_freeze_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !load_i) |=> $stable(cnt_q));

  assert_tick_reload_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && !load_i) |=> (cnt_q == $past(reload_i)));
endmodule

// File: rtl/lt_intcnt.sv
`timescale 1ns/1ps
module lt_intcnt #(
  parameter int unsigned ICNT_W = 31
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              load_i,
  input  logic              interval_i,
  input  logic [ICNT_W-1:0] reload_i,
  output logic              expire_o
);
  logic [ICNT_W-1:0] cnt_q;
  logic              done_q;

  // counts of 0 and 1 both expire on the next tick
  assign expire_o = tick_i && !done_q && (cnt_q <= ICNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      done_q <= 1'b1;
    end else if (load_i) begin
      cnt_q  <= reload_i;
      done_q <= 1'b0;
    end else if (expire_o) begin
      if (interval_i) cnt_q <= reload_i;
      else begin
        cnt_q  <= '0;
        done_q <= 1'b1;
      end
    end else if (tick_i && !done_q) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assert_oneshot_done_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire_o && !interval_i && !load_i) |=> done_q);

  assert_oneshot_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_q && !load_i) |=> (done_q && cnt_q == '0));

  assert_interval_reload_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire_o && interval_i && !load_i) |=> (cnt_q == $past(reload_i) && !done_q));
endmodule

// File: rtl/lt_regs.sv
`timescale 1ns/1ps
module lt_regs
  import lt_pkg::*;
#(
  parameter int unsigned TICK_W = 32,
  parameter int unsigned ICNT_W = 31
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              expire_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [TICK_W-1:0] tick_reload_o,
  output logic [ICNT_W-1:0] icnt_reload_o,
  output logic              run_o,
  output logic              load_o,
  output logic              interval_o,
  output logic              irq_o
);
  logic [TICK_W-1:0]   tick_buf_q;
  logic [UPD_BIT-1:0]  icnt_buf_q;
  logic [ICNT_W-1:0]   icnt_act_q;
  ctl_t                ctl_q;
  logic                stat_q;
  logic                en_q;

  logic wr, wr_tick, wr_icnt, wr_ctl, wr_stat, wr_en;
  logic clr_req;
  logic unused_wdata;

  assign wr      = req_i && we_i;
  assign wr_tick = wr && (addr_i == OFF_TICK);
  assign wr_icnt = wr && (addr_i == OFF_ICNT);
  assign wr_ctl  = wr && (addr_i == OFF_CTL);
  assign wr_stat = wr && (addr_i == OFF_STAT);
  assign wr_en   = wr && (addr_i == OFF_EN);
  assign clr_req = wr_stat && wdata_i[0];
  assign unused_wdata = ^wdata_i[DATA_W-1:3];

  assign run_o      = ctl_q.tick_run && ctl_q.int_run;
  assign interval_o = ctl_q.interval;
  // start edge: both start bits written while not both already set
  assign load_o     = wr_ctl && wdata_i[0] && wdata_i[1] && !run_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tick_buf_q <= '0;
      icnt_buf_q <= '0;
      icnt_act_q <= '0;
      ctl_q      <= '0;
      en_q       <= 1'b0;
    end else begin
      if (wr_tick) tick_buf_q <= wdata_i[TICK_W-1:0];
      if (wr_icnt) begin
        icnt_buf_q <= wdata_i[UPD_BIT-1:0];
        if (wdata_i[UPD_BIT]) icnt_act_q <= wdata_i[ICNT_W-1:0];
      end
      if (wr_ctl) ctl_q <= ctl_t'(wdata_i[2:0]);
      if (wr_en)  en_q  <= wdata_i[0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       stat_q <= 1'b0;
    else if (expire_i) stat_q <= 1'b1;
    else if (clr_req)  stat_q <= 1'b0;
  end

  assign tick_reload_o = tick_buf_q;
  assign icnt_reload_o = icnt_act_q;
  assign irq_o         = stat_q && en_q;

  always_comb begin
    unique case (addr_i)
      OFF_TICK: rdata_o = DATA_W'(tick_buf_q);
      OFF_ICNT: rdata_o = {1'b0, icnt_buf_q};
      OFF_CTL:  rdata_o = {{(DATA_W-3){1'b0}}, ctl_q};
      OFF_STAT: rdata_o = {{(DATA_W-1){1'b0}}, stat_q};
      OFF_EN:   rdata_o = {{(DATA_W-1){1'b0}}, en_q};
      default:  rdata_o = '0;
    endcase
  end

  assert_set_wins_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_i |=> stat_q);

  assert_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_q && !clr_req) |=> stat_q);

  assert_no_update_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_icnt && wdata_i[UPD_BIT]) |=> $stable(icnt_act_q));
endmodule

// File: rtl/local_tick_timer.sv
`timescale 1ns/1ps
module local_tick_timer #(
  parameter int unsigned TICK_W = 32,
  parameter int unsigned ICNT_W = 31
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_i,
  input  logic        we_i,
  input  logic [7:0]  addr_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  output logic        irq_o
);
  logic [TICK_W-1:0] tick_reload;
  logic [ICNT_W-1:0] icnt_reload;
  logic run, load, interval, tick, expire;

  lt_regs #(.TICK_W(TICK_W), .ICNT_W(ICNT_W)) u_regs (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .wdata_i,
    .expire_i      (expire),
    .rdata_o,
    .tick_reload_o (tick_reload),
    .icnt_reload_o (icnt_reload),
    .run_o         (run),
    .load_o        (load),
    .interval_o    (interval),
    .irq_o
  );

  lt_prescaler #(.TICK_W(TICK_W)) u_presc (
    .clk_i, .rst_ni,
    .run_i    (run),
    .load_i   (load),
    .reload_i (tick_reload),
    .tick_o   (tick)
  );

  lt_intcnt #(.ICNT_W(ICNT_W)) u_icnt (
    .clk_i, .rst_ni,
    .tick_i     (tick),
    .load_i     (load),
    .interval_i (interval),
    .reload_i   (icnt_reload),
    .expire_o   (expire)
  );

  assert_expire_needs_run_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire |-> run);
endmodule

// File: tb/local_tick_timer_tb.sv
`timescale 1ns/1ps
module local_tick_timer_tb;
  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic req_i = 1'b0, we_i = 1'b0;
  logic [7:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        irq_o;

  int total = 0, bad = 0, cyc = 0, wr_cyc = 0;

  local_tick_timer u_dut (.*);

  always #4 clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;

  localparam logic [7:0] A_TICK = 8'h00, A_ICNT = 8'h08, A_CTL = 8'h20,
                         A_STAT = 8'h30, A_EN = 8'h34;

  task automatic check(input bit ok, input string rq, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    req_i = 1'b1; we_i = 1'b1; addr_i = a; wdata_i = d;
    @(posedge clk_i); #1 wr_cyc = cyc;
    @(negedge clk_i);
    req_i = 1'b0; we_i = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    addr_i = a; #1 d = rdata_o;
  endtask

  task automatic wait_irq(input int limit, output int at);
    at = -1;
    for (int i = 0; i < limit; i++) begin
      if (irq_o) begin at = cyc; break; end
      @(negedge clk_i);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  initial begin
    wait (cyc >= 150000);
    total++; bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int s, e, p;
    idle(3);
    rst_ni = 1'b1;
    idle(1);

    // R1 reset state
    check(irq_o == 1'b0, "R1 irq", irq_o, 0);
    foreach (u_addrs[i]) begin
      rd(u_addrs[i], d);
      check(d == 0, "R1 reset read", d, 0);
    end

    // R3 readback and unmapped offset
    wr(A_TICK, 32'h0000_00A5);
    rd(A_TICK, d); check(d == 32'hA5, "R3 tick buffer", d, 32'hA5);
    wr(A_EN, 32'h1);
    rd(A_EN, d); check(d == 1, "R3 enable", d, 1);
    rd(8'h10, d); check(d == 0, "R3 unmapped", d, 0);

    // R2/R6 sweep: prescaler 0..3, count 15..17, two recurring periods
    for (int t = 0; t < 4; t++) begin
      for (int n = 15; n < 18; n++) begin
        p = n * (t + 1);
        wr(A_CTL, 0); wr(A_STAT, 1);
        wr(A_TICK, t); wr(A_ICNT, 32'h8000_0000 | n);
        wr(A_CTL, 3'b111); s = wr_cyc;
        wait_irq(500, e);
        check(e - s == p, "R2 first period", e - s, p);
        wr(A_STAT, 1);
        check(irq_o == 1'b0, "R8 w1c clears", irq_o, 0);
        wait_irq(500, e);
        check(e - s == 2 * p, "R6 recurring", e - s, 2 * p);
      end
    end
    wr(A_CTL, 0); wr(A_STAT, 1);

    // R8 write-zero no effect, R9 gating
    wr(A_TICK, 0); wr(A_ICNT, 32'h8000_000F);
    wr(A_CTL, 3'b011); s = wr_cyc;
    wait_irq(500, e);
    check(e - s == 15, "R2 first period", e - s, 15);
    wr(A_STAT, 0);
    rd(A_STAT, d); check(d == 1, "R8 write zero keeps", d, 1);
    wr(A_EN, 0);
    check(irq_o == 1'b0, "R9 masked", irq_o, 0);
    wr(A_EN, 1);
    check(irq_o == 1'b1, "R9 unmasked", irq_o, 1);

    // R7 one-shot: one flag only
    wr(A_STAT, 1);
    idle(100);
    rd(A_STAT, d); check(d == 0, "R7 single expiry", d, 0);
    wr(A_CTL, 0);

    // R4 update bit
    wr(A_ICNT, 32'h0000_0014);
    rd(A_ICNT, d); check(d == 32'h14, "R4 readback", d, 32'h14);
    wr(A_CTL, 3'b111); s = wr_cyc;
    wait_irq(500, e);
    check(e - s == 15, "R4 no update", e - s, 15);
    wr(A_CTL, 0); wr(A_STAT, 1);
    wr(A_ICNT, 32'h8000_0010);
    rd(A_ICNT, d); check(d == 32'h10, "R4 bit31 hidden", d, 32'h10);
    wr(A_TICK, 1);
    wr(A_CTL, 3'b111); s = wr_cyc;
    wait_irq(500, e);
    check(e - s == 32, "R4 updated count", e - s, 32);
    wr(A_CTL, 0); wr(A_STAT, 1);

    // R5 freeze and restart reload
    wr(A_TICK, 0); wr(A_ICNT, 32'h8000_0014);
    wr(A_CTL, 3'b111);
    idle(5);
    wr(A_CTL, 3'b100);
    idle(100);
    rd(A_STAT, d); check(d == 0, "R5 frozen", d, 0);
    wr(A_CTL, 3'b101);
    rd(A_CTL, d); check(d == 3'b101, "R3 control", d, 5);
    idle(100);
    rd(A_STAT, d); check(d == 0, "R5 tick-only", d, 0);
    wr(A_CTL, 3'b111); s = wr_cyc;
    wait_irq(500, e);
    check(e - s == 20, "R5 reload on start", e - s, 20);
    wr(A_CTL, 0); wr(A_STAT, 1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  logic [7:0] u_addrs [5] = '{8'h00, 8'h08, 8'h20, 8'h30, 8'h34};
endmodule